// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor bus 24 general-purpose I/O lines, grouped as port A (8 bits), port B (8 bits) and port C (8 bits). Port C is split into an upper and a lower nibble, and each nibble has its own direction. The bus side has an 8-bit data path, two address bits and three strobes, all active low: chip select, read and write. Each I/O line is modelled as a pad triple: a pin input, a driven output value and an output enable. This suits tri-state pads outside the block.

Only basic mode is supported. Software writes one command address that carries two command formats, chosen by bit 7. With bit 7 set, the command is a configuration word that sets the direction of each port and nibble. With bit 7 clear, the command sets or clears one port C bit and does not change the configuration. A port set as output drives its latched value. A port set as input is read straight from its pins, with no latching. Bus writes are handled in a system clock domain: each write strobe takes effect once, on the first clock edge that sees it low.

Top module: `ppi_port_unit`

## Requirements
- R1: The address selects the register: 0 is port A, 1 is port B, 2 is port C, 3 is the command register.
- R2: Nothing is read or written while cs_n is high. A write occurs once per low phase of wr_n, on the first rising clock edge at which cs_n and wr_n are both low.
- R3: The command register is write-only. A read at address 3 leaves dout_oe low and dout at 0.
- R4: A command with bit 7 = 1 sets the directions, where 1 means input: bit 4 for port A, bit 3 for the port C upper nibble, bit 1 for port B and bit 0 for the port C lower nibble. Bits 6:5 and bit 2 select handshake modes that this block does not have, and they do not affect its behaviour.
- R5: Command 0x90 makes port A an input and makes ports B and C (both nibbles) outputs.
- R6: A command with bit 7 = 0 writes port C latch bit number din[3:1] with the value din[0]. The directions and all other latch bits are unchanged.
- R7: An output port drives its latch on its pin outputs with the output enable high. A port set as input has its output enable low. Reading an input port returns the present pin values, with no latching.
- R8: Reading a port set as output returns its latched value.
- R9: Reset sets every port to input and clears all output latches.
- R10: Every configuration command clears all three output latches.
- R11: dout_oe is high only while cs_n and rd_n are both low and the address is 0, 1 or 2. At all other times dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_oe | output | 1 | Bus drive enable for dout |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, one per nibble |

## Verification
The hardest case to reach is a port C read in which one nibble is an input and the other is an output. The returned byte must then take half its bits from the pins and half from the latch. The bench first sets both nibbles as outputs and loads the latch. It then sends a configuration command that makes only the upper nibble an input, which also clears the latch. It reloads the latch and drives different values on the pins, so that each half of the read byte can be traced to its source. Set/reset commands are checked after a latch value is already present, to show that only the addressed bit changes and that the directions stay as they were.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_C    = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // direction flags, 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_rst_sync.sv
module ppi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ppi_cmd_decode.sv
module ppi_cmd_decode
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output dir_t          dir,
  output logic          cfg_wr,
  output logic          sr_wr,
  output logic [BW-1:0] sr_bit,
  output logic          sr_val
);
  dir_t dir_q, dir_d;
  logic ctrl_wr;
  logic unused_mode_bits;

  assign ctrl_wr = wr_stb && (addr == SEL_CTRL);
  assign cfg_wr  = ctrl_wr &&  din[7];
  assign sr_wr   = ctrl_wr && !din[7];
  assign sr_bit  = din[BW:1];
  assign sr_val  = din[0];
  assign unused_mode_bits = ^{din[6:5], din[2]};

  always_comb begin
    dir_d = dir_q;
    if (cfg_wr) begin
      dir_d.a_in  = din[4];
      dir_d.cu_in = din[3];
      dir_d.b_in  = din[1];
      dir_d.cl_in = din[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_ALL_IN;
    else if (cfg_wr) dir_q <= dir_d;
  end

  assign dir = dir_q;

  // set/reset format never alters the directions
  assert_sr_keeps_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr |=> $stable(dir_q));
  // directions follow the configuration word fields
  assert_cfg_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (dir_q.a_in == $past(din[4])) && (dir_q.b_in == $past(din[1])));
endmodule

// File: rtl/ppi_out_latch.sv
module ppi_out_latch #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          bit_we,
  input  logic [BW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r, q_d;
  logic          en;

  assign en = clr || ld || bit_we;

  always_comb begin
    q_d = q_r;
    if (clr)         q_d = '0;
    else if (ld)     q_d = ld_data;
    else if (bit_we) q_d[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q_r == '0));
  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !clr && !ld) |=> ($countones(q_r ^ $past(q_r)) <= 1)
                                && (q_r[$past(bit_idx)] == $past(bit_val)));
endmodule

// File: rtl/ppi_port_unit.sv
module ppi_port_unit
  import ppi_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW),
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  logic          rst_sync_n;
  logic          wr_q;
  logic          wr_stb;
  dir_t          dir;
  logic          cfg_wr, sr_wr, sr_val;
  logic [BW-1:0] sr_bit;
  logic [DW-1:0] a_q, b_q, c_q;
  logic [DW-1:0] c_rd;
  logic [DW-1:0] rd_val;
  logic          rd_en;

  ppi_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // strobe edge detect: one write per low phase of wr_n
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) wr_q <= 1'b1;
    else             wr_q <= wr_n;
  end
  assign wr_stb = !cs_n && !wr_n && wr_q;

  ppi_cmd_decode #(.DW(DW)) i_cmd (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .addr(addr), .din(din),
    .dir(dir), .cfg_wr(cfg_wr), .sr_wr(sr_wr), .sr_bit(sr_bit), .sr_val(sr_val)
  );

  ppi_out_latch #(.DW(DW)) i_latch_a (
    .clk(clk), .rst_n(rst_sync_n), .clr(cfg_wr), .ld(wr_stb && addr == SEL_A),
    .ld_data(din), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(a_q)
  );
  ppi_out_latch #(.DW(DW)) i_latch_b (
    .clk(clk), .rst_n(rst_sync_n), .clr(cfg_wr), .ld(wr_stb && addr == SEL_B),
    .ld_data(din), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(b_q)
  );
  ppi_out_latch #(.DW(DW)) i_latch_c (
    .clk(clk), .rst_n(rst_sync_n), .clr(cfg_wr), .ld(wr_stb && addr == SEL_C),
    .ld_data(din), .bit_we(sr_wr), .bit_idx(sr_bit), .bit_val(sr_val), .q(c_q)
  );

  // pad side
  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = {DW{!dir.a_in}};
  assign pb_oe  = {DW{!dir.b_in}};
  assign pc_oe  = {{HW{!dir.cu_in}}, {HW{!dir.cl_in}}};

  // port C read: each nibble picks pins or latch on its own
  generate
    for (genvar h = 0; h < 2; h++) begin : g_c_half
      logic half_in;
      assign half_in = (h == 1) ? dir.cu_in : dir.cl_in;
      assign c_rd[h*HW +: HW] = half_in ? pc_in[h*HW +: HW] : c_q[h*HW +: HW];
    end
  endgenerate

  always_comb begin
    case (addr)
      SEL_A:   rd_val = dir.a_in ? pa_in : a_q;
      SEL_B:   rd_val = dir.b_in ? pb_in : b_q;
      SEL_C:   rd_val = c_rd;
      default: rd_val = '0;
    endcase
  end

  assign rd_en   = !cs_n && !rd_n && (addr != SEL_CTRL);
  assign dout_oe = rd_en;
  assign dout    = rd_en ? rd_val : '0;

  // deselected bus leaves every latch untouched
  assert_cs_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_n |=> $stable(a_q) && $stable(b_q) && $stable(c_q));
  // a write strobe held low commits only once
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb |=> !wr_stb);
  // output port read returns what the pads drive
  assert_out_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cs_n && !rd_n && addr == SEL_A && pa_oe[0]) |-> (dout == pa_out));
  // command address never drives the bus
  assert_ctrl_no_read_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr == SEL_CTRL) |-> !dout_oe);
endmodule

// File: tb/test_ppi_port_unit.sv
module test_ppi_port_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int errors = 0;
  int checks = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;  // 125 MHz

  ppi_port_unit i_ppi_port_unit (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk);
    cs_n = sel_n; addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);  // strobe held two edges: still one write
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    #1 d = dout;
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    pa_in = 8'h3C;
    do_reset();
    check("R9 pa_oe", pa_oe, 8'h00);
    check("R9 pb_oe", pb_oe, 8'h00);
    check("R9 pc_oe", pc_oe, 8'h00);
    check("R9 pc_out", {pa_out, pb_out, pc_out}, 24'h0);
    bus_read(2'd0, rv);
    check("R7 reset read A pins", rv, 8'h3C);
  endtask

  task automatic t_addr_map();
    bus_write(2'd3, 8'h80);  // all outputs
    bus_write(2'd0, 8'h11);
    bus_write(2'd1, 8'h22);
    bus_write(2'd2, 8'h33);
    check("R1 port A latch", pa_out, 8'h11);
    check("R1 port B latch", pb_out, 8'h22);
    check("R1 port C latch", pc_out, 8'h33);
    check("R7 outputs enabled", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
    pa_in = 8'hEE;
    bus_read(2'd0, rv); check("R8 read output A", rv, 8'h11);
    bus_read(2'd1, rv); check("R8 read output B", rv, 8'h22);
    bus_read(2'd2, rv); check("R8 read output C", rv, 8'h33);
  endtask

  task automatic t_cs_and_ctrl_read();
    bus_write(2'd0, 8'h99, 1'b1);  // chip not selected
    check("R2 deselected write ignored", pa_out, 8'h11);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0; addr = 2'd0;
    #1 check("R11 no drive without cs", {dout_oe, dout}, 9'h000);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 2'd3;
    #1 check("R3 control read not driven", {dout_oe, dout}, 9'h000);
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 2'd1;
    #1 check("R11 drive on valid read", dout_oe, 1'b1);
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_setreset();
    bus_write(2'd3, 8'h0F);  // bit 7 <- 1
    check("R6 set bit7", pc_out, 8'hB3);
    bus_write(2'd3, 8'h00);  // bit 0 <- 0
    check("R6 clear bit0", pc_out, 8'hB2);
    bus_write(2'd3, 8'h0E);  // bit 7 <- 0
    check("R6 clear bit7", pc_out, 8'h32);
    check("R6 directions kept", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
    check("R6 other latches kept", {pa_out, pb_out}, 16'h1122);
  endtask

  task automatic t_cfg_clear();
    bus_write(2'd3, 8'hE4);  // mode bits set, all directions output
    check("R10 latches cleared", {pa_out, pb_out, pc_out}, 24'h0);
    check("R4 mode bits no effect", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
  endtask

  task automatic t_0x90();
    bus_write(2'd3, 8'h90);
    check("R5 A input", pa_oe, 8'h00);
    check("R5 B and C output", {pb_oe, pc_oe}, 16'hFFFF);
    pa_in = 8'h5A;
    bus_read(2'd0, rv); check("R7 live read 1", rv, 8'h5A);
    pa_in = 8'hA7;
    bus_read(2'd0, rv); check("R7 live read 2", rv, 8'hA7);
    bus_write(2'd0, 8'h44);
    check("R7 input port latch stored not driven", {pa_oe, pa_out}, 16'h0044);
  endtask

  task automatic t_dir_bits();
    bus_write(2'd3, 8'h82);
    check("R4 bit1 port B", {pa_oe, pb_oe, pc_oe}, 24'hFF00FF);
    bus_write(2'd3, 8'h81);
    check("R4 bit0 C lower", pc_oe, 8'hF0);
    bus_write(2'd3, 8'h88);
    check("R4 bit3 C upper", pc_oe, 8'h0F);
    bus_write(2'd2, 8'h36);
    pc_in = 8'hA5;
    bus_read(2'd2, rv);
    check("R4 mixed port C read", rv, 8'hA6);
    pb_in = 8'h71;
    bus_read(2'd1, rv);
    check("R8 B output not pins", rv, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_map();
    t_cs_and_ctrl_read();
    t_setreset();
    t_cfg_clear();
    t_0x90();
    t_dir_bits();
    bus_write(2'd0, 8'h00);
    bus_write(2'd3, 8'h80);
    bus_write(2'd1, 8'hC3);
    do_reset();
    check("R9 reset clears after use", {pb_out, pb_oe}, 16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule